// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a memory-mapped watchdog built around two cascaded countdown stages. After a reload, stage one counts its preload down in prescaled ticks. When it runs out, the block records a stage-one interrupt and stage two begins counting its own preload. When stage two runs out, the block sets a sticky timeout flag and, in watchdog mode, requests a reset. Software must reload the block before both stages run out.

The preload registers and the reload register are guarded by a key sequence. Two key values written to the reload register open a gate that admits exactly one protected write. A lock register holds the enable, the mode and a sticky lock bit that software cannot clear. A config register selects the tick divisor, can block the reset request, and selects how the interrupt is signalled.

The block has one state machine for the key gate, with the states KEY_IDLE, KEY_HALF and KEY_OPEN, and one for the countdown, with the states ST_STAGE1, ST_STAGE2 and ST_TRIPPED. The key gate takes these transitions:
- KEY_IDLE to KEY_HALF when the first key is written.
- KEY_HALF to KEY_OPEN when the second key is written.
- KEY_HALF stays in KEY_HALF when the first key is written again.
- KEY_HALF to KEY_IDLE on any other reload write.
- KEY_OPEN to KEY_IDLE on any protected write.

The countdown takes these transitions:
- Any state to ST_STAGE1 on a reload.
- ST_STAGE1 to ST_STAGE2 when stage one expires.
- ST_STAGE2 to ST_TRIPPED when stage two expires in watchdog mode.
- ST_STAGE2 to ST_STAGE1 when stage two expires in free-running mode.

Top module: `twostage_wdog`

## Requirements
- R1: Writing 0x0080 to the reload register (offset 0x0C, low 16 bits) and then 0x0086 opens the key gate. Writes to other offsets between the two keys do not disturb the sequence.
- R2: An open gate admits exactly one protected write (preload 1 at 0x00, preload 2 at 0x04, or reload at 0x0C) and then closes again. A protected write made while the gate is closed is ignored.
- R3: A reload write that breaks the key sequence returns the gate to KEY_IDLE. A repeated 0x0080 keeps the gate half-open.
- R4: A protected reload write with bit 8 set clears the prescaler and restarts stage one from preload 1. A stage with preload P lasts max(P,1) ticks.
- R5: When stage one expires, bit 0 of the status register (0x08, write 1 to clear) is set. The irq output depends on config bits 1:0: 00 makes irq a level that follows status bit 0, 01 makes irq a one-cycle pulse, and 10 or 11 gives no irq.
- R6: When stage two expires, the timeout flag (bit 9 of the reload register) is set. In watchdog mode, rst_req is held high until the next reload, unless config bit 5 is 1.
- R7: The timeout flag is sticky. A protected reload write with bit 9 set clears it, and bit 9 may be combined with bit 8 in the same write.
- R8: The lock register (0x14) has lock at bit 0, enable at bit 1 and mode at bit 2. Once lock is 1, lock and enable cannot be cleared and the mode bit is frozen; only rst_n releases them.
- R9: Config bit 2 selects the tick: 0 gives one tick per 2^DIV_SLOW enabled clocks, and 1 gives one tick per 2^DIV_FAST enabled clocks.
- R10: While enable is 0, the prescaler and both stages hold their state and irq and rst_req stay low. Counting resumes from the held state when enable returns to 1.
- R11: With mode bit 1 (free-running), stage-two expiry sets the timeout flag, never raises rst_req, and restarts stage one from preload 1.
- R12: After reset, both preloads equal PRE_RST, config, lock, status and timeout are 0, the key gate is in KEY_IDLE, and irq and rst_req are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Stage-one interrupt |
| rst_req | output | 1 | Reset request on stage-two expiry |

## Verification
The hardest situation to reach is an expiry that lands on an exact cycle after enable has been dropped partway through a tick. The prescaler and the stage counter must both resume from their held values, and nothing can be read back to show them. The stimulus reloads the block, removes enable a known number of cycles into the first tick, waits a long time, and then restores enable. The expected expiry cycle is then counted from the enabled clocks alone. Randomized rounds vary the preloads, the tick divisor, the interrupt type and the reset gate. They sample each output one cycle before and exactly at the computed expiry edge.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_t;

    typedef enum logic [1:0] {
        ST_STAGE1  = 2'd0,
        ST_STAGE2  = 2'd1,
        ST_TRIPPED = 2'd2
    } wd_state_t;

    typedef enum logic [1:0] {
        IRQ_LEVEL = 2'b00,
        IRQ_PULSE = 2'b01,
        IRQ_RSVD  = 2'b10,
        IRQ_OFF   = 2'b11
    } irq_kind_t;

    localparam logic [15:0] KEY_FIRST  = 16'h0080;
    localparam logic [15:0] KEY_SECOND = 16'h0086;

    localparam int OFS_PRE1 = 'h00;
    localparam int OFS_PRE2 = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_RLD  = 'h0C;
    localparam int OFS_CFG  = 'h10;
    localparam int OFS_LOCK = 'h14;

    localparam int RLD_GO_BIT  = 8;
    localparam int RLD_TMO_BIT = 9;
    localparam int LK_LOCK_BIT = 0;
    localparam int LK_EN_BIT   = 1;
    localparam int LK_MODE_BIT = 2;
    localparam int CF_FAST_BIT = 2;
    localparam int CF_NORST_BIT = 5;

endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate
    import twostage_wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reload_wr,
    input  logic        prot_wr,
    input  logic [15:0] key_data,
    output logic        grant
);

    key_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            KEY_IDLE: if (reload_wr && key_data == KEY_FIRST) nxt = KEY_HALF;
            KEY_HALF: begin
                if (reload_wr) begin
                    if (key_data == KEY_SECOND)     nxt = KEY_OPEN;
                    else if (key_data == KEY_FIRST) nxt = KEY_HALF;
                    else                            nxt = KEY_IDLE;
                end
            end
            KEY_OPEN: if (prot_wr) nxt = KEY_IDLE;
            default:  nxt = KEY_IDLE;
        endcase
    end

    always_comb begin
        grant = (state == KEY_OPEN);
    end

    // R1
    open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(reload_wr && key_data == KEY_SECOND));

    // R2
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && prot_wr) |=> !grant);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV_SLOW = 15,
    parameter int DIV_FAST = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    input  logic restart,
    output logic tick
);

    localparam logic [DIV_SLOW-1:0] SLOW_MASK = {DIV_SLOW{1'b1}};
    localparam logic [DIV_SLOW-1:0] FAST_MASK = SLOW_MASK >> (DIV_SLOW - DIV_FAST);

    logic [DIV_SLOW-1:0] cnt;
    logic [DIV_SLOW-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    always_comb begin
        mask = fast ? FAST_MASK : SLOW_MASK;
        tick = run && ((cnt & mask) == mask);
    end

    // R4
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import twostage_wdog_pkg::*;
#(
    parameter int PRE_W   = 20,
    parameter int PRE_RST = 15360
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic             free_run,
    input  logic [PRE_W-1:0] pre1,
    input  logic [PRE_W-1:0] pre2,
    output wd_state_t        stage,
    output logic             s1_exp,
    output logic             s2_exp
);

    wd_state_t        st, nxt;
    logic [PRE_W-1:0] remain, nrem;
    logic             last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_STAGE1;
            remain <= PRE_W'(PRE_RST);
        end else begin
            st     <= nxt;
            remain <= nrem;
        end
    end

    assign last = (remain <= PRE_W'(1));

    always_comb begin
        nxt  = st;
        nrem = remain;
        if (reload) begin
            nxt  = ST_STAGE1;
            nrem = pre1;
        end else if (tick) begin
            unique case (st)
                ST_STAGE1: begin
                    if (last) begin
                        nxt  = ST_STAGE2;
                        nrem = pre2;
                    end else nrem = remain - 1'b1;
                end
                ST_STAGE2: begin
                    if (last) begin
                        if (free_run) begin
                            nxt  = ST_STAGE1;
                            nrem = pre1;
                        end else nxt = ST_TRIPPED;
                    end else nrem = remain - 1'b1;
                end
                ST_TRIPPED: nxt = ST_TRIPPED;
                default:    nxt = ST_STAGE1;
            endcase
        end
    end

    always_comb begin
        stage  = st;
        s1_exp = tick && !reload && (st == ST_STAGE1) && last;
        s2_exp = tick && !reload && (st == ST_STAGE2) && last;
    end

    // R6
    stage2_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STAGE2 && $past(st) != ST_STAGE2) |-> $past(st) == ST_STAGE1);

    // R6
    tripped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRIPPED && !reload) |=> st == ST_TRIPPED);

endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import twostage_wdog_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int PRE_W    = 20,
    parameter int PRE_RST  = 15360,
    parameter int DIV_SLOW = 15,
    parameter int DIV_FAST = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    localparam logic [ADDR_W-1:0] A_PRE1 = ADDR_W'(OFS_PRE1);
    localparam logic [ADDR_W-1:0] A_PRE2 = ADDR_W'(OFS_PRE2);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(OFS_RLD);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);

    logic [PRE_W-1:0] pre1_q, pre2_q;
    logic             irq_stat_q, tmo_q, pulse_q;
    logic             cfg_norst_q, cfg_fast_q;
    irq_kind_t        cfg_kind_q;
    logic             lock_q, en_q, mode_q;

    logic wr_pre1, wr_pre2, wr_stat, wr_rld, wr_cfg, wr_lock;
    logic prot_wr, grant, take;
    logic reload_cmd, tmo_clr;
    logic tick, s1_exp, s2_exp;
    wd_state_t stage;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        wr_pre1 = bus_wr && bus_addr == A_PRE1;
        wr_pre2 = bus_wr && bus_addr == A_PRE2;
        wr_stat = bus_wr && bus_addr == A_STAT;
        wr_rld  = bus_wr && bus_addr == A_RLD;
        wr_cfg  = bus_wr && bus_addr == A_CFG;
        wr_lock = bus_wr && bus_addr == A_LOCK;
        prot_wr = wr_pre1 || wr_pre2 || wr_rld;
        take    = prot_wr && grant;
        reload_cmd = take && wr_rld && bus_wdata[RLD_GO_BIT];
        tmo_clr    = take && wr_rld && bus_wdata[RLD_TMO_BIT];
    end

    wdog_keygate u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_wr(wr_rld),
        .prot_wr  (prot_wr),
        .key_data (bus_wdata[15:0]),
        .grant    (grant)
    );

    wdog_prescaler #(
        .DIV_SLOW(DIV_SLOW),
        .DIV_FAST(DIV_FAST)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en_q),
        .fast   (cfg_fast_q),
        .restart(reload_cmd),
        .tick   (tick)
    );

    wdog_countdown #(
        .PRE_W  (PRE_W),
        .PRE_RST(PRE_RST)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .reload  (reload_cmd),
        .free_run(mode_q),
        .pre1    (pre1_q),
        .pre2    (pre2_q),
        .stage   (stage),
        .s1_exp  (s1_exp),
        .s2_exp  (s2_exp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre1_q      <= PRE_W'(PRE_RST);
            pre2_q      <= PRE_W'(PRE_RST);
            irq_stat_q  <= 1'b0;
            tmo_q       <= 1'b0;
            pulse_q     <= 1'b0;
            cfg_norst_q <= 1'b0;
            cfg_fast_q  <= 1'b0;
            cfg_kind_q  <= IRQ_LEVEL;
            lock_q      <= 1'b0;
            en_q        <= 1'b0;
            mode_q      <= 1'b0;
        end else begin
            if (take && wr_pre1) pre1_q <= bus_wdata[PRE_W-1:0];
            if (take && wr_pre2) pre2_q <= bus_wdata[PRE_W-1:0];
            if (s1_exp)                         irq_stat_q <= 1'b1;
            else if (wr_stat && bus_wdata[0])   irq_stat_q <= 1'b0;
            if (s2_exp)       tmo_q <= 1'b1;
            else if (tmo_clr) tmo_q <= 1'b0;
            pulse_q <= s1_exp;
            if (wr_cfg) begin
                cfg_norst_q <= bus_wdata[CF_NORST_BIT];
                cfg_fast_q  <= bus_wdata[CF_FAST_BIT];
                cfg_kind_q  <= irq_kind_t'(bus_wdata[1:0]);
            end
            if (wr_lock) begin
                if (lock_q) begin
                    en_q <= en_q | bus_wdata[LK_EN_BIT];
                end else begin
                    lock_q <= bus_wdata[LK_LOCK_BIT];
                    en_q   <= bus_wdata[LK_EN_BIT];
                    mode_q <= bus_wdata[LK_MODE_BIT];
                end
            end
        end
    end

    always_comb begin
        irq = en_q && ((cfg_kind_q == IRQ_LEVEL && irq_stat_q) ||
                       (cfg_kind_q == IRQ_PULSE && pulse_q));
        rst_req = en_q && !mode_q && !cfg_norst_q && (stage == ST_TRIPPED);
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PRE1: bus_rdata = 32'(pre1_q);
            A_PRE2: bus_rdata = 32'(pre2_q);
            A_STAT: bus_rdata[0] = irq_stat_q;
            A_RLD:  bus_rdata[RLD_TMO_BIT] = tmo_q;
            A_CFG: begin
                bus_rdata[CF_NORST_BIT] = cfg_norst_q;
                bus_rdata[CF_FAST_BIT]  = cfg_fast_q;
                bus_rdata[1:0]          = cfg_kind_q;
            end
            A_LOCK: begin
                bus_rdata[LK_LOCK_BIT] = lock_q;
                bus_rdata[LK_EN_BIT]   = en_q;
                bus_rdata[LK_MODE_BIT] = mode_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R8
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && en_q) |=> en_q);

    // R7
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_q && !tmo_clr) |=> tmo_q);

    // R6
    tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_exp |=> tmo_q);

    // R5
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_exp |=> irq_stat_q);

endmodule

// File: tb/twostage_wdog_tb.sv
`timescale 1ns/1ps
module twostage_wdog_tb;

    localparam int DSLOW = 4;
    localparam int DFAST = 2;
    localparam int PRST  = 7;

    localparam int A_PRE1 = 'h00;
    localparam int A_PRE2 = 'h04;
    localparam int A_STAT = 'h08;
    localparam int A_RLD  = 'h0C;
    localparam int A_CFG  = 'h10;
    localparam int A_LOCK = 'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    twostage_wdog #(
        .ADDR_W(5), .PRE_W(20), .PRE_RST(PRST),
        .DIV_SLOW(DSLOW), .DIV_FAST(DFAST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_addr = 5'(a);
        bus_wdata = 32'(d);
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input int a, output int v);
        bus_addr = 5'(a);
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic unlock();
        wr(A_RLD, 'h80);
        wr(A_RLD, 'h86);
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic int span(input int p, input bit fast);
        return p * (fast ? (1 << DFAST) : (1 << DSLOW));
    endfunction

    function automatic int irq_exp(input int kind);
        return (kind == 0 || kind == 1) ? 1 : 0;
    endfunction

    task automatic run_cycle(input int p1, input int p2, input bit fast, input int kind,
                             input bit norst, input bit free, output int e);
        int v, d1, d2;
        wr(A_CFG, (int'(norst) << 5) | (int'(fast) << 2) | kind);
        wr(A_LOCK, (int'(free) << 2) | 2);
        unlock(); wr(A_PRE1, p1);
        unlock(); wr(A_PRE2, p2);
        unlock(); wr(A_RLD, 'h300);
        e = cyc;
        peek(A_RLD, v); check("R7 timeout cleared with reload", v, 0);
        wr(A_STAT, 1);
        d1 = span(p1, fast);
        d2 = span(p2, fast);
        wait_to(e + d1 - 1);
        peek(A_STAT, v); check("R5 status before stage1 expiry", v, 0);
        check("R5 irq before stage1 expiry", int'(irq), 0);
        wait_to(e + d1);
        peek(A_STAT, v); check("R4 R9 status at stage1 expiry", v, 1);
        check("R5 irq at stage1 expiry", int'(irq), irq_exp(kind));
        if (kind == 1) begin
            wait_to(e + d1 + 1);
            check("R5 pulse irq lasts one cycle", int'(irq), 0);
        end
        wait_to(e + d1 + d2 - 1);
        check("R6 rst_req before stage2 expiry", int'(rst_req), 0);
        peek(A_RLD, v); check("R6 timeout before stage2 expiry", v, 0);
        wait_to(e + d1 + d2);
        peek(A_RLD, v); check("R6 timeout flag at stage2 expiry", v, 'h200);
        check("R6 R11 rst_req at stage2 expiry", int'(rst_req), (!norst && !free) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R12 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int v, e, f, seed;
        seed = int'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        peek(A_PRE1, v); check("R12 preload1 reset", v, PRST);
        peek(A_PRE2, v); check("R12 preload2 reset", v, PRST);
        peek(A_CFG, v);  check("R12 config reset", v, 0);
        peek(A_LOCK, v); check("R12 lock reset", v, 0);
        peek(A_STAT, v); check("R12 status reset", v, 0);
        peek(A_RLD, v);  check("R12 timeout reset", v, 0);
        check("R12 irq reset", int'(irq), 0);
        check("R12 rst_req reset", int'(rst_req), 0);

        // R2 protected write without unlock is ignored
        wr(A_PRE1, 'h55);
        peek(A_PRE1, v); check("R2 locked preload1 write ignored", v, PRST);

        // R1 other-address write between keys; R2 single write then relock
        wr(A_RLD, 'h80); wr(A_CFG, 0); wr(A_RLD, 'h86);
        wr(A_PRE1, 'h11);
        peek(A_PRE1, v); check("R1 unlocked preload1 write", v, 'h11);
        wr(A_PRE2, 'h22);
        peek(A_PRE2, v); check("R2 second write after relock ignored", v, PRST);

        // R3 broken sequence
        wr(A_RLD, 'h80); wr(A_RLD, 'h55); wr(A_RLD, 'h86);
        wr(A_PRE2, 'h33);
        peek(A_PRE2, v); check("R3 broken key sequence", v, PRST);
        wr(A_RLD, 'h80); wr(A_RLD, 'h80); wr(A_RLD, 'h86);
        wr(A_PRE2, 'h34);
        peek(A_PRE2, v); check("R3 repeated first key stays half-open", v, 'h34);

        // directed corners
        run_cycle(3, 2, 1'b0, 0, 1'b0, 1'b0, e);   // R9 slow divisor
        run_cycle(1, 1, 1'b1, 3, 1'b1, 1'b0, e);   // R6 reset gated, irq off
        run_cycle(2, 1, 1'b1, 1, 1'b0, 1'b0, e);   // R5 pulse

        // constrained random rounds
        for (int i = 0; i < 20; i++) begin
            int p1, p2, kind;
            bit fast, norst;
            p1 = 1 + int'($urandom % 5);
            p2 = 1 + int'($urandom % 5);
            fast = 1'($urandom % 2);
            kind = int'($urandom % 4);
            norst = ($urandom % 3) == 0;
            run_cycle(p1, p2, fast, kind, norst, 1'b0, e);
        end

        // R11 free-running: stage1 restarts after stage2 expiry
        run_cycle(2, 3, 1'b1, 0, 1'b0, 1'b1, e);
        wr(A_STAT, 1);
        wait_to(e + 8 + 12 + 8 - 1);
        peek(A_STAT, v); check("R11 status before restarted stage1 expiry", v, 0);
        wait_to(e + 8 + 12 + 8);
        peek(A_STAT, v); check("R11 stage1 restarted from preload1", v, 1);
        check("R11 no rst_req in free-running mode", int'(rst_req), 0);

        // R10 enable low holds counting
        wr(A_CFG, 4);
        wr(A_LOCK, 2);
        unlock(); wr(A_PRE1, 2);
        unlock(); wr(A_PRE2, 8);
        unlock(); wr(A_RLD, 'h300);
        e = cyc;
        wr(A_STAT, 1);
        wait_to(e + 4);
        wr(A_LOCK, 0);
        wait_to(e + 60);
        check("R10 irq low while disabled", int'(irq), 0);
        peek(A_STAT, v); check("R10 no expiry while disabled", v, 0);
        check("R10 rst_req low while disabled", int'(rst_req), 0);
        wr(A_LOCK, 2);
        f = cyc;
        wait_to(f + 2);
        peek(A_STAT, v); check("R10 held count not yet expired", v, 0);
        wait_to(f + 3);
        peek(A_STAT, v); check("R10 expiry after held count resumes", v, 1);
        check("R10 level irq after resume", int'(irq), 1);

        // R8 sticky lock
        wr(A_LOCK, 3);
        peek(A_LOCK, v); check("R8 lock and enable set", v, 3);
        wr(A_LOCK, 0);
        peek(A_LOCK, v); check("R8 lock and enable cannot be cleared", v, 3);
        wr(A_LOCK, 4);
        peek(A_LOCK, v); check("R8 mode frozen while locked", v, 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule